// File: doc/BRIEF.md
# Magnetometer Register File

This block models the slave side of a three-axis magnetic sensor's 8-bit register space. It sits behind a plain parallel register bus with an address, write data, a write strobe, a read strobe and read data. Read data is registered: the byte for an address presented with `reg_rd` appears on `reg_rdata` one clock later. The block holds the identifier, the four measurement pairs, a status byte, the power bit, the mode and rate byte, and the interrupt, data-ready, threshold and repetition bytes. It also holds a read-only trim area whose contents come from a parameter.

A measurement-complete strobe, `meas_done`, carries fresh raw samples on the sample inputs. The block stores them left-justified in their register pairs and raises a data-ready flag. The flag drives the `drdy` pin at a selectable polarity. Reading the X low byte clears the flag. Forced mode takes one sample and then drops back to sleep.

Top module: `magn_regfile`

## Requirements
- R1: While powered, a read of address 0x40 returns the constant 0x32.
- R2: While bit 0 of 0x4B is clear (suspend), reads of every address other than 0x4B return 0x00 and have no side effect. Writes to every address other than 0x4B are ignored, and `meas_done` is ignored. The other registers keep their contents through suspend.
- R3: Only addresses 0x4B through 0x52 accept writes, and each of them reads back the full byte written. A write to a data address or a trim address leaves its contents unchanged.
- R4: After reset, 0x4B reads 0x00 and 0x4C reads 0x06 (sleep mode). All other writable registers read 0x00.
- R5: A `meas_done` pulse while powered and in normal (0x4C bits 2:1 = 00) or forced (01) mode stores the samples little-endian at these addresses: X as {x,3'b000} at 0x42/0x43, Y as {y,3'b000} at 0x44/0x45, Z as {z,1'b0} at 0x46/0x47, and hall as {rh,2'b00} at 0x48/0x49. In sleep mode (11) the pulse is ignored.
- R6: The data-ready flag is set by an accepted sample only when bit 7 of 0x4E is set. No other event sets it.
- R7: A powered read of 0x42 clears the data-ready flag. Reads of the other data addresses leave it set.
- R8: Bits 3, 4 and 5 of 0x4E gate the update of the X, Y and Z pairs respectively. The hall pair is always updated by an accepted sample.
- R9: `drdy` equals the flag when bit 2 of 0x4E is 1, and the inverted flag when it is 0.
- R10: Addresses 0x5D to 0x71 return byte (address − 0x5D) of the `TRIM_BYTES` parameter, with byte 0 in the least significant bits.
- R11: Reads of addresses outside 0x40–0x52 and 0x5D–0x71, and of 0x41, return 0x00.
- R12: An accepted sample in forced mode changes 0x4C bits 2:1 to 11 and keeps the other bits of 0x4C.
- R13: Bit 0 of status address 0x4A mirrors the data-ready flag, the other bits read 0, and reading 0x4A does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| meas_done | input | 1 | Measurement-complete strobe carrying the samples |
| samp_x | input | 13 | Raw signed X sample |
| samp_y | input | 13 | Raw signed Y sample |
| samp_z | input | 15 | Raw signed Z sample |
| samp_rh | input | 14 | Raw unsigned hall-resistance sample |
| drdy | output | 1 | Data-ready pin, polarity set by 0x4E bit 2 |

## Verification
The properties assume that the strobes and the address carry known values once reset is released. They also assume that a write to a data address never arrives in the same cycle as `meas_done`, because then the new sample would legitimately change the pair. The stimulus issues at most one bus strobe per cycle and never overlaps a bus access with a `meas_done` pulse. This also keeps the read-clear and sample-set cases apart.

// File: rtl/magn_regfile.sv
module magn_regfile #(
  parameter logic [7:0]   ID_VALUE   = 8'h32,
  parameter logic [167:0] TRIM_BYTES = 168'h14_E7_1A_00_6C_00_00_C6_0A_F9_28_00_00_8A_1D_42_05_1F_33_7B_D1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  input  logic        reg_wr,
  input  logic        reg_rd,
  output logic [7:0]  reg_rdata,
  input  logic        meas_done,
  input  logic [12:0] samp_x,
  input  logic [12:0] samp_y,
  input  logic [14:0] samp_z,
  input  logic [13:0] samp_rh,
  output logic        drdy
);

  logic [7:0]  power_q, opmode_q, intcfg_q, drcfg_q, lothr_q, hithr_q, repxy_q, repz_q;
  logic [15:0] ax_q, ay_q, az_q, rh_q;
  logic        ready_q;
  logic [7:0]  rd_val;
  logic [7:0]  trim_off;

  wire       pwr_on   = power_q[0];
  wire [1:0] mode     = opmode_q[2:1];
  wire       meas_ok  = meas_done && pwr_on && (mode == 2'b00 || mode == 2'b01);
  wire       rd_clear = reg_rd && pwr_on && (reg_addr == 8'h42);
  wire       wr_ok    = reg_wr && (pwr_on || reg_addr == 8'h4B);

  assign trim_off = reg_addr - 8'h5D;
  assign drdy     = drcfg_q[2] ? ready_q : ~ready_q;

  always_comb begin
    rd_val = 8'h00;
    if (!pwr_on) begin
      if (reg_addr == 8'h4B) rd_val = power_q;
    end else begin
      case (reg_addr)
        8'h40: rd_val = ID_VALUE;
        8'h42: rd_val = ax_q[7:0];
        8'h43: rd_val = ax_q[15:8];
        8'h44: rd_val = ay_q[7:0];
        8'h45: rd_val = ay_q[15:8];
        8'h46: rd_val = az_q[7:0];
        8'h47: rd_val = az_q[15:8];
        8'h48: rd_val = rh_q[7:0];
        8'h49: rd_val = rh_q[15:8];
        8'h4A: rd_val = {7'b0, ready_q};
        8'h4B: rd_val = power_q;
        8'h4C: rd_val = opmode_q;
        8'h4D: rd_val = intcfg_q;
        8'h4E: rd_val = drcfg_q;
        8'h4F: rd_val = lothr_q;
        8'h50: rd_val = hithr_q;
        8'h51: rd_val = repxy_q;
        8'h52: rd_val = repz_q;
        default: begin
          if (reg_addr >= 8'h5D && reg_addr <= 8'h71)
            rd_val = TRIM_BYTES[{trim_off[4:0], 3'b000} +: 8];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      power_q  <= 8'h00;
      opmode_q <= 8'h06;
      intcfg_q <= 8'h00;
      drcfg_q  <= 8'h00;
      lothr_q  <= 8'h00;
      hithr_q  <= 8'h00;
      repxy_q  <= 8'h00;
      repz_q   <= 8'h00;
    end else begin
      if (wr_ok) begin
        case (reg_addr)
          8'h4B: power_q  <= reg_wdata;
          8'h4C: opmode_q <= reg_wdata;
          8'h4D: intcfg_q <= reg_wdata;
          8'h4E: drcfg_q  <= reg_wdata;
          8'h4F: lothr_q  <= reg_wdata;
          8'h50: hithr_q  <= reg_wdata;
          8'h51: repxy_q  <= reg_wdata;
          8'h52: repz_q   <= reg_wdata;
          default: ;
        endcase
      end
      if (meas_ok && mode == 2'b01) opmode_q[2:1] <= 2'b11;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ax_q <= 16'h0000;
      ay_q <= 16'h0000;
      az_q <= 16'h0000;
      rh_q <= 16'h0000;
    end else if (meas_ok) begin
      if (drcfg_q[3]) ax_q <= {samp_x, 3'b000};
      if (drcfg_q[4]) ay_q <= {samp_y, 3'b000};
      if (drcfg_q[5]) az_q <= {samp_z, 1'b0};
      rh_q <= {samp_rh, 2'b00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      reg_rdata <= 8'h00;
    end else begin
      if (meas_ok && drcfg_q[7]) ready_q <= 1'b1;
      else if (rd_clear)         ready_q <= 1'b0;
      if (reg_rd) reg_rdata <= rd_val;
    end
  end

endmodule

// File: rtl/magn_regfile_chk.sv
module magn_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  reg_addr,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [7:0]  reg_rdata,
  input logic        meas_done,
  input logic        pwr_on,
  input logic        ready_q,
  input logic [1:0]  mode,
  input logic [15:0] ax_q
);

  AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && pwr_on && reg_addr == 8'h40) |=> reg_rdata == 8'h32); // R1

  AST_SUSPEND_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !pwr_on && reg_addr != 8'h4B) |=> reg_rdata == 8'h00); // R2

  AST_DATA_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h42 && !meas_done) |=> $stable(ax_q)); // R3

  AST_READY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(meas_done)); // R6

  AST_READY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && pwr_on && reg_addr == 8'h42 && !meas_done) |=> !ready_q); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && pwr_on && (reg_addr < 8'h40 || reg_addr > 8'h71)) |=> reg_rdata == 8'h00); // R11

  AST_FORCED_TO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_done && pwr_on && mode == 2'b01 && !reg_wr) |=> mode == 2'b11); // R12

  AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && pwr_on && reg_addr == 8'h4A) |=> reg_rdata == {7'b0, $past(ready_q)}); // R13

endmodule

bind magn_regfile magn_regfile_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_rdata (reg_rdata),
  .meas_done (meas_done),
  .pwr_on    (pwr_on),
  .ready_q   (ready_q),
  .mode      (mode),
  .ax_q      (ax_q)
);

// File: tb/magn_regfile_bench.sv
module magn_regfile_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [167:0] TRIM = 168'hA1_02_B3_04_C5_06_D7_08_E9_0A_FB_0C_1D_0E_2F_10_41_12_63_14_85;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [7:0]  reg_wdata = 8'h00;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_rdata;
  logic        meas_done = 1'b0;
  logic [12:0] samp_x = '0;
  logic [12:0] samp_y = '0;
  logic [14:0] samp_z = '0;
  logic [13:0] samp_rh = '0;
  logic        drdy;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic rd_pend = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  magn_regfile #(.TRIM_BYTES(TRIM)) u_magn_regfile (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .meas_done(meas_done), .samp_x(samp_x), .samp_y(samp_y),
    .samp_z(samp_z), .samp_rh(samp_rh), .drdy(drdy)
  );

  always @(posedge clk) rd_pend <= reg_rd;

  always @(negedge clk) begin
    if (rd_pend) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (reg_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: rdata actual %02h expected %02h", t, reg_rdata, e);
      end
    end
  end

  task automatic do_read(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    reg_addr = a;
    reg_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    reg_wdata = d;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_meas(input logic [12:0] x, input logic [12:0] y,
                         input logic [14:0] z, input logic [13:0] rh);
    @(negedge clk);
    samp_x = x; samp_y = y; samp_z = z; samp_rh = rh;
    meas_done = 1'b1;
    @(negedge clk);
    meas_done = 1'b0;
  endtask

  task automatic check_pin(input logic e, input string t);
    n_cmp++;
    if (drdy !== e) begin
      n_bad++;
      $display("FAIL %s: drdy actual %0b expected %0b", t, drdy, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    do_read(8'h4B, 8'h00, "R4 power reset");
    check_pin(1'b1, "R9 idle active-low");
    do_read(8'h40, 8'h00, "R2 suspended id");
    do_write(8'h51, 8'h55);
    do_write(8'h4B, 8'h01);
    do_read(8'h51, 8'h00, "R2 write ignored in suspend");
    do_read(8'h40, 8'h32, "R1 id");
    do_read(8'h4C, 8'h06, "R4 mode reset");
    do_read(8'h4E, 8'h00, "R4 drdy cfg reset");
    do_read(8'h4D, 8'h00, "R4 int cfg reset");

    do_write(8'h42, 8'hAA);
    do_read(8'h42, 8'h00, "R3 data not writable");
    do_write(8'h5D, 8'hFF);
    do_read(8'h5D, TRIM[7:0], "R10 trim first");
    do_read(8'h71, TRIM[167:160], "R10 trim last");
    do_read(8'h66, TRIM[79:72], "R10 trim mid");
    do_read(8'h5C, 8'h00, "R11 below trim");
    do_read(8'h41, 8'h00, "R11 reserved");
    do_read(8'h72, 8'h00, "R11 above trim");
    do_read(8'hF0, 8'h00, "R11 high");

    do_write(8'h4D, 8'hA5);
    do_write(8'h4F, 8'h3C);
    do_write(8'h50, 8'hC3);
    do_write(8'h51, 8'h17);
    do_write(8'h52, 8'h29);
    do_read(8'h4D, 8'hA5, "R3 readback 4D");
    do_read(8'h4F, 8'h3C, "R3 readback 4F");
    do_read(8'h50, 8'hC3, "R3 readback 50");
    do_read(8'h51, 8'h17, "R3 readback 51");
    do_read(8'h52, 8'h29, "R3 readback 52");

    do_write(8'h4E, 8'hBC);
    do_meas(13'h1FFD, 13'h0123, 15'h4321, 14'h2345);
    check_pin(1'b0, "R6 no ready in sleep");
    do_read(8'h43, 8'h00, "R5 sleep ignores sample");

    do_write(8'h4C, 8'h28);
    do_meas(13'h1FFD, 13'h0123, 15'h4321, 14'h2345);
    check_pin(1'b1, "R6 ready set");
    do_read(8'h4A, 8'h01, "R13 status set");
    do_read(8'h43, 8'hFF, "R5 X msb");
    check_pin(1'b1, "R7 other read keeps ready");
    do_read(8'h44, 8'h18, "R5 Y lsb");
    do_read(8'h45, 8'h09, "R5 Y msb");
    do_read(8'h46, 8'h42, "R5 Z lsb");
    do_read(8'h47, 8'h86, "R5 Z msb");
    do_read(8'h48, 8'h14, "R5 hall lsb");
    do_read(8'h49, 8'h8D, "R5 hall msb");
    do_read(8'h42, 8'hE8, "R5 X lsb");
    check_pin(1'b0, "R7 cleared by X lsb read");
    do_read(8'h4A, 8'h00, "R13 status clear");

    do_write(8'h4E, 8'h8C);
    do_meas(13'h0001, 13'h0FFF, 15'h0000, 14'h0001);
    do_read(8'h44, 8'h18, "R8 Y disabled");
    do_read(8'h46, 8'h42, "R8 Z disabled");
    do_read(8'h48, 8'h04, "R8 hall always");
    do_read(8'h42, 8'h08, "R8 X enabled");

    do_write(8'h4E, 8'h0C);
    do_meas(13'h0002, 13'h0000, 15'h0000, 14'h0000);
    check_pin(1'b0, "R6 ready disabled");
    do_read(8'h42, 8'h10, "R5 load without ready");

    do_write(8'h4E, 8'h88);
    check_pin(1'b1, "R9 active-low idle");
    do_meas(13'h0003, 13'h0000, 15'h0000, 14'h0000);
    check_pin(1'b0, "R9 active-low asserted");
    do_read(8'h42, 8'h18, "R9 data");
    check_pin(1'b1, "R9 active-low released");

    do_write(8'h4C, 8'h2A);
    do_meas(13'h0004, 13'h0000, 15'h0000, 14'h0000);
    check_pin(1'b0, "R12 forced sample ready");
    do_read(8'h4C, 8'h2E, "R12 back to sleep");
    do_meas(13'h0005, 13'h0000, 15'h0000, 14'h0000);
    do_read(8'h42, 8'h20, "R12 no second sample");

    do_write(8'h4C, 8'h28);
    do_meas(13'h0006, 13'h0000, 15'h0000, 14'h0000);
    check_pin(1'b0, "R2 ready before suspend");
    do_write(8'h4B, 8'h00);
    do_read(8'h4B, 8'h00, "R2 power readable");
    do_read(8'h42, 8'h00, "R2 suspended data read");
    check_pin(1'b0, "R2 no clear in suspend");
    do_write(8'h4C, 8'h06);
    do_meas(13'h0007, 13'h0000, 15'h0000, 14'h0000);
    do_write(8'h4B, 8'h01);
    do_read(8'h4C, 8'h28, "R2 mode kept");
    do_read(8'h42, 8'h30, "R2 sample ignored in suspend");
    check_pin(1'b1, "R7 clear after resume");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule